// File: doc/BRIEF.md
# ADC Result Formatting Register Pair

This block captures the 10-bit value delivered by a single-channel analog-to-digital conversion and presents it to a processor as two byte-wide readable registers: an upper byte and a lower byte. A 2-bit mode input selects one of four layouts for the value. The layout is applied when a result is stored, so a mode change only affects results stored after it.

Software reads the upper byte first and the lower byte second. The upper-byte read arms an interlock that freezes both registers. From that point until the lower byte is read, every new conversion result is thrown away. This means the two bytes a program reads always belong to the same conversion. A sticky flag records that at least one result was discarded in this way.

Read data is combinational: it is valid in the same cycle as the read strobe. The read port decodes two byte addresses. Reset is asynchronous and active-low, and its release is synchronised to the clock inside the block.

Top module: `adc_result_pair`

## Requirements
- R1: After reset, both registers read 0x00, the overrun flag is 0 and the interlock is clear.
- R2: Mode 00 (truncated) stores the upper byte as 0x00 and the lower byte as value bits 9..2.
- R3: Mode 01 (right-aligned) stores value bits 9..8 in upper-byte bits 1..0, with upper bits 7..2 zero, and stores value bits 7..0 in the lower byte.
- R4: Mode 10 (left-aligned) stores value bits 9..2 in the upper byte, and stores value bits 1..0 in lower-byte bits 7..6, with lower bits 5..0 zero.
- R5: Mode 11 (signed left-aligned) uses the mode 10 layout with upper-byte bit 7 inverted.
- R6: A completion strobe with the interlock clear loads both registers at the next clock edge, using the mode present on that strobe. A later mode change does not alter stored data.
- R7: A read at the upper address (0x59) arms the interlock. While it is armed, both registers hold their contents, and a discarded value never appears at the read port.
- R8: A read at the lower address (0x5A) clears the interlock. A strobe in that same cycle is still discarded. The next strobe after it is accepted.
- R9: A lower-address read without a preceding upper read returns the current data and leaves the interlock clear.
- R10: When a strobe coincides with an upper-address read, the read returns the old data and the new value is discarded.
- R11: The overrun output goes to 1 when a strobe is discarded and stays at 1 until reset.
- R12: The read data is 0x00 whenever the read strobe is low or the address matches neither register. Otherwise the selected register appears in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_done | input | 1 | Conversion-complete strobe, one cycle |
| conv_value | input | 10 | Conversion result |
| mode | input | 2 | Layout select: 00 truncated, 01 right, 10 left, 11 signed left |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 8 | Register byte address |
| rd_data | output | 8 | Read data, combinational |
| overrun | output | 1 | Sticky flag for a discarded result |

## Verification
The bench builds the block with its default parameters: a 10-bit result, byte-wide registers and the upper and lower registers at 0x59 and 0x5A. With a 10-bit result in a 16-bit pair, the two shift amounts differ (2 bits dropped in truncated mode, 6 bits of padding in the left-aligned modes). This lets every bit-placement mistake show up as a visible value difference. The directed sequences cover three coincidences: a strobe landing on an upper read, a strobe landing on a lower read, and strobes arriving while the pair is frozen. A random phase then mixes strobes, modes and reads at both addresses and at a stray address, and compares against the behavioural model on every clock.

// File: rtl/adc_fmt_pkg.sv
package adc_fmt_pkg;
  typedef enum logic [1:0] {
    FMT_TRUNC = 2'b00,
    FMT_RIGHT = 2'b01,
    FMT_LEFT  = 2'b10,
    FMT_LSIGN = 2'b11
  } fmt_mode_e;
endpackage

// File: rtl/adc_rst_sync.sv
module adc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/adc_result_format.sv
module adc_result_format
  import adc_fmt_pkg::*;
#(
  parameter int RES_W  = 10,
  parameter int BYTE_W = 8
) (
  input  logic [RES_W-1:0]  sample,
  input  fmt_mode_e         fmt,
  output logic [BYTE_W-1:0] hi_byte,
  output logic [BYTE_W-1:0] lo_byte
);
  localparam int PAIR_W = 2 * BYTE_W;
  localparam int LSHIFT = PAIR_W - RES_W;
  localparam int TDROP  = RES_W - BYTE_W;

  logic [PAIR_W-1:0] right_w, left_w, sign_w, trunc_w, pick_w;

  always_comb begin
    right_w = PAIR_W'(sample);
    left_w  = right_w << LSHIFT;
    sign_w  = left_w ^ {1'b1, {(PAIR_W-1){1'b0}}};
    trunc_w = PAIR_W'(sample >> TDROP);
    case (fmt)
      FMT_TRUNC: pick_w = trunc_w;
      FMT_RIGHT: pick_w = right_w;
      FMT_LEFT:  pick_w = left_w;
      FMT_LSIGN: pick_w = sign_w;
      default:   pick_w = right_w;
    endcase
  end

  assign hi_byte = pick_w[PAIR_W-1:BYTE_W];
  assign lo_byte = pick_w[BYTE_W-1:0];
endmodule

// File: rtl/adc_read_lock.sv
module adc_read_lock (
  input  logic clk,
  input  logic rst_n,
  input  logic conv_done,
  input  logic rd_hi,
  input  logic rd_lo,
  output logic accept,
  output logic lock_q,
  output logic overrun_q
);
  logic lock_d, lock_en;
  logic ovr_d, ovr_en;

  always_comb begin
    accept  = conv_done & ~lock_q & ~rd_hi;
    lock_en = rd_hi | rd_lo;
    lock_d  = rd_hi;
    ovr_en  = conv_done & ~accept;
    ovr_d   = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q    <= 1'b0;
      overrun_q <= 1'b0;
    end else begin
      if (lock_en) lock_q    <= lock_d;
      if (ovr_en)  overrun_q <= ovr_d;
    end
  end
endmodule

// File: rtl/adc_result_pair.sv
module adc_result_pair
  import adc_fmt_pkg::*;
#(
  parameter int                RES_W       = 10,
  parameter int                BYTE_W      = 8,
  parameter int                ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] HI_ADDR     = 'h59,
  parameter logic [ADDR_W-1:0] LO_ADDR     = 'h5A,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_done,
  input  logic [RES_W-1:0]  conv_value,
  input  logic [1:0]        mode,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [BYTE_W-1:0] rd_data,
  output logic              overrun
);
  logic              rst_ns;
  logic              rd_hi, rd_lo, accept, lock_q;
  logic [BYTE_W-1:0] fmt_hi, fmt_lo;
  logic [BYTE_W-1:0] hi_q, lo_q, hi_d, lo_d;

  adc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(rst_ns)
  );

  assign rd_hi = rd_en && (rd_addr == HI_ADDR);
  assign rd_lo = rd_en && (rd_addr == LO_ADDR);

  adc_result_format #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_fmt (
    .sample(conv_value), .fmt(fmt_mode_e'(mode)),
    .hi_byte(fmt_hi), .lo_byte(fmt_lo)
  );

  adc_read_lock u_lock (
    .clk(clk), .rst_n(rst_ns), .conv_done(conv_done),
    .rd_hi(rd_hi), .rd_lo(rd_lo), .accept(accept),
    .lock_q(lock_q), .overrun_q(overrun)
  );

  always_comb begin
    hi_d = fmt_hi;
    lo_d = fmt_lo;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (accept) begin
      hi_q <= hi_d;
      lo_q <= lo_d;
    end
  end

  always_comb begin
    if (rd_hi)      rd_data = hi_q;
    else if (rd_lo) rd_data = lo_q;
    else            rd_data = '0;
  end
endmodule

// File: rtl/adc_result_pair_chk.sv
module adc_result_pair_chk #(
  parameter int                BYTE_W  = 8,
  parameter int                ADDR_W  = 8,
  parameter logic [ADDR_W-1:0] HI_ADDR = 'h59,
  parameter logic [ADDR_W-1:0] LO_ADDR = 'h5A
) (
  input logic              clk,
  input logic              rst_n,
  input logic              conv_done,
  input logic [1:0]        mode,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [BYTE_W-1:0] rd_data,
  input logic [BYTE_W-1:0] hi_q,
  input logic [BYTE_W-1:0] lo_q,
  input logic              lock_q,
  input logic              overrun
);
  logic hi_rd, lo_rd;
  assign hi_rd = rd_en && (rd_addr == HI_ADDR);
  assign lo_rd = rd_en && (rd_addr == LO_ADDR);

  assert_trunc_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && !lock_q && !hi_rd && mode == 2'b00) |=> hi_q == '0);
  assert_arm_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hi_rd |=> lock_q);
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> ($stable(hi_q) && $stable(lo_q)));
  assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && lo_rd) |=> !lock_q);
  assert_no_arm_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_q && !hi_rd) |=> !lock_q);
  assert_coincide_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && hi_rd) |=> ($stable(hi_q) && $stable(lo_q)));
  assert_ovr_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && lock_q) |=> overrun);
  assert_ovr_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
  assert_idle_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> rd_data == '0);
endmodule

bind adc_result_pair adc_result_pair_chk #(
  .BYTE_W(BYTE_W), .ADDR_W(ADDR_W), .HI_ADDR(HI_ADDR), .LO_ADDR(LO_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_ns), .conv_done(conv_done), .mode(mode),
  .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
  .hi_q(hi_q), .lo_q(lo_q), .lock_q(lock_q), .overrun(overrun)
);

// File: tb/adc_result_pair_test.sv
`timescale 1ns/1ps
module adc_result_pair_test;
  localparam logic [7:0] A_HI = 8'h59;
  localparam logic [7:0] A_LO = 8'h5A;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       conv_done;
  logic [9:0] conv_value;
  logic [1:0] mode;
  logic       rd_en;
  logic [7:0] rd_addr;
  logic [7:0] rd_data;
  logic       overrun;

  int checks = 0;
  int errors = 0;

  // reference model state
  int m_hi = 0, m_lo = 0, m_lock = 0, m_ovr = 0;

  always #4 clk = ~clk;

  adc_result_pair uut (
    .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .conv_value(conv_value),
    .mode(mode), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .overrun(overrun)
  );

  function automatic int pack16(input int v, input int md);
    int w;
    case (md)
      0: w = v / 4;
      1: w = v;
      2: w = v * 64;
      default: w = (v * 64) ^ 32768;
    endcase
    return w;
  endfunction

  task automatic cyc(input bit done, input int val, input int md,
                     input bit re, input logic [7:0] addr, input string tag);
    int exp_rd;
    bit is_hi, is_lo;
    int w;
    @(negedge clk);
    conv_done = done; conv_value = 10'(val); mode = 2'(md);
    rd_en = re; rd_addr = addr;
    #1;
    is_hi = re && (addr == A_HI);
    is_lo = re && (addr == A_LO);
    exp_rd = is_hi ? m_hi : (is_lo ? m_lo : 0);
    checks++;
    if (int'(rd_data) != exp_rd) begin
      errors++;
      $display("FAIL %s rd_data actual %02h expected %02h", tag, rd_data, exp_rd);
    end
    checks++;
    if (int'(overrun) != m_ovr) begin
      errors++;
      $display("FAIL %s overrun actual %0d expected %0d", tag, overrun, m_ovr);
    end
    @(posedge clk);
    if (done) begin
      if (m_lock == 0 && !is_hi) begin
        w = pack16(val, md);
        m_hi = (w / 256) % 256;
        m_lo = w % 256;
      end else m_ovr = 1;
    end
    if (is_hi) m_lock = 1;
    else if (is_lo) m_lock = 0;
  endtask

  task automatic idle(input string tag);
    cyc(0, 0, 0, 0, 8'h00, tag);
  endtask

  task automatic read_pair(input string tag);
    cyc(0, 0, 0, 1, A_HI, tag);
    cyc(0, 0, 0, 1, A_LO, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; conv_done = 0; conv_value = '0; mode = '0; rd_en = 0; rd_addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 reset state
    idle("R1");
    read_pair("R1");
    // R12 stray address and idle
    cyc(0, 0, 0, 1, 8'h58, "R12");
    cyc(0, 0, 0, 1, 8'h5B, "R12");

    // R2..R5 layouts
    cyc(1, 'h2B5, 0, 0, 0, "R2"); read_pair("R2");
    cyc(1, 'h3FF, 0, 0, 0, "R2"); read_pair("R2");
    cyc(1, 'h2B5, 1, 0, 0, "R3"); read_pair("R3");
    cyc(1, 'h1C3, 1, 0, 0, "R3"); read_pair("R3");
    cyc(1, 'h2B5, 2, 0, 0, "R4"); read_pair("R4");
    cyc(1, 'h003, 2, 0, 0, "R4"); read_pair("R4");
    cyc(1, 'h2B5, 3, 0, 0, "R5"); read_pair("R5");
    cyc(1, 'h000, 3, 0, 0, "R5"); read_pair("R5");

    // R6 mode change after store does not alter data
    cyc(1, 'h155, 1, 0, 0, "R6");
    cyc(0, 0, 2, 0, 0, "R6");
    read_pair("R6");

    // R7 frozen pair, dropped values never seen
    cyc(1, 'h0A7, 2, 0, 0, "R7");
    cyc(0, 0, 2, 1, A_HI, "R7");
    cyc(1, 'h3FF, 2, 0, 0, "R7");
    cyc(1, 'h2AA, 1, 0, 0, "R7");
    cyc(0, 0, 0, 1, A_LO, "R7");
    read_pair("R7");
    // R11 overrun now held
    idle("R11");
    idle("R11");

    // R8 strobe on the releasing read is dropped, next accepted
    cyc(0, 0, 0, 1, A_HI, "R8");
    cyc(1, 'h111, 1, 1, A_LO, "R8");
    cyc(1, 'h222, 1, 0, 0, "R8");
    read_pair("R8");

    // R9 lower read alone leaves interlock clear
    cyc(1, 'h0F0, 1, 0, 0, "R9");
    cyc(0, 0, 0, 1, A_LO, "R9");
    cyc(1, 'h30F, 1, 0, 0, "R9");
    cyc(0, 0, 0, 1, A_LO, "R9");
    cyc(0, 0, 0, 1, A_HI, "R9");
    cyc(0, 0, 0, 1, A_LO, "R9");

    // R10 strobe coinciding with upper read
    cyc(1, 'h1E1, 2, 1, A_HI, "R10");
    cyc(0, 0, 0, 1, A_LO, "R10");
    read_pair("R10");

    // R6 random mix compared every clock
    for (int i = 0; i < 600; i++) begin
      int sel;
      logic [7:0] a;
      sel = $urandom_range(0, 3);
      a = (sel == 0) ? A_HI : (sel == 1) ? A_LO : (sel == 2) ? 8'h40 : A_HI;
      cyc(bit'($urandom_range(0, 1)), int'($urandom_range(0, 1023)),
          int'($urandom_range(0, 3)), bit'($urandom_range(0, 1)), a, "R6");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule